// File: doc/BRIEF.md
# Periodic Detector Telemetry Frame Builder

Each acquisition period a tick arrives. On that tick the block captures eight 12-bit converter samples, eight 8-bit counter values, a 10-bit status word and a 10-bit card identifier. It adds a 16-bit frame sequence number to these values and builds a 256-bit frame. The frame holds 224 bits of zero-padded data followed by a 32-bit CRC over that data. A downstream serializer takes the frame as sixteen 16-bit words through a valid/ready handshake. The most significant word is sent first.

All inputs are latched on the tick, so the front ends may present new values while a frame is still leaving. The CRC is computed as the data words are handed over, one 16-bit word per accepted beat. This means the two check words follow the last data word with no gap. A tick that arrives while a frame is still in flight is discarded and raises a sticky overrun flag.

Top module: `frame_crc_packer`

## Requirements
- R1: A tick seen while `out_valid` is low is accepted. From the next cycle `out_valid` is high and word 0 of the new frame is on `out_data`. The frame content is taken from the input values present at that tick.
- R2: The frame is a 256-bit vector sent as 16 words, most significant word first. From the most significant bit down, it holds: channel 0 to 7 samples (channel k is `adc_in[12k+11:12k]`), channel 0 to 7 counters (`cnt_in[8k+7:8k]`), `status_in`, `card_id`, the 16-bit sequence number, 28 zero bits, and the CRC. Words 0 to 13 are the 224 data bits.
- R3: Words 14 and 15 carry the upper and lower halves of the CRC. The CRC is computed over the 224 data bits, most significant bit first, with polynomial 0x04C11DB7, no bit reflection, a start value of all ones and a final inversion.
- R4: `out_last` is high exactly while word 15 is presented.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady. After the handshake on word 15, `out_valid` is low in the next cycle.
- R6: The sequence number is 0 in the first frame after reset. It rises by one for each accepted frame and wraps at 16 bits. A discarded tick does not advance it.
- R7: A tick seen while `out_valid` is high starts nothing. This includes the cycle in which word 15 is handed over. Such a tick sets `overrun`, which then stays high until reset.
- R8: Input changes after the accepting tick have no effect on the frame being sent.
- R9: During and right after reset, `out_valid`, `out_last` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Acquisition period strobe |
| adc_in | input | 96 | Eight 12-bit converter samples, channel 0 in the low bits |
| cnt_in | input | 64 | Eight 8-bit counter values, channel 0 in the low bits |
| status_in | input | 10 | Status word |
| card_id | input | 10 | Card identifier |
| out_ready | input | 1 | Serializer accepts the current word |
| out_valid | output | 1 | A frame word is presented |
| out_data | output | 16 | Frame word |
| out_last | output | 1 | Final word of the frame |
| overrun | output | 1 | Sticky: a tick was discarded |

## Verification
A new tick and the handshake of the final word can land in the same cycle. The bench provokes this by watching for `out_last` with `out_ready` high and raising `tick` in that very cycle. It then expects the tick to be dropped: `out_valid` must fall the next cycle, `overrun` must rise, and the sequence number of the next accepted frame must not have moved. A reference model built on queues decides this case and every other cycle independently. The same model judges ticks that coincide with long stalls of `out_ready`.

// File: rtl/frame_crc_packer.sv
module frame_crc_packer #(
  parameter int NCH    = 8,
  parameter int SMP_W  = 12,
  parameter int CNT_W  = 8,
  parameter int STAT_W = 10,
  parameter int ID_W   = 10,
  parameter int SEQ_W  = 16,
  parameter int WORD_W = 16,
  parameter int DATA_W = 224,
  parameter int CRC_W  = 32,
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [NCH*SMP_W-1:0]   adc_in,
  input  logic [NCH*CNT_W-1:0]   cnt_in,
  input  logic [STAT_W-1:0]      status_in,
  input  logic [ID_W-1:0]        card_id,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [WORD_W-1:0]      out_data,
  output logic                   out_last,
  output logic                   overrun
);

  localparam int PAY_W  = NCH*SMP_W + NCH*CNT_W + STAT_W + ID_W + SEQ_W;
  localparam int PAD_W  = DATA_W - PAY_W;
  localparam int DWORDS = DATA_W / WORD_W;
  localparam int NWORDS = (DATA_W + CRC_W) / WORD_W;
  localparam int IW     = $clog2(NWORDS);
  localparam int CNT_HI = DATA_W - NCH*SMP_W;

  logic [DATA_W-1:0] data_sh, frame_w;
  logic [CRC_W-1:0]  crc;
  logic [IW-1:0]     idx;
  logic [SEQ_W-1:0]  seq;
  logic              in_data;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                 input logic [WORD_W-1:0] w);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int b = WORD_W-1; b >= 0; b--) begin
      fb = c[CRC_W-1] ^ w[b];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  always_comb begin
    frame_w = '0;
    for (int k = 0; k < NCH; k++) begin
      frame_w[DATA_W-1-k*SMP_W -: SMP_W] = adc_in[k*SMP_W +: SMP_W];
      frame_w[CNT_HI-1-k*CNT_W -: CNT_W] = cnt_in[k*CNT_W +: CNT_W];
    end
    frame_w[PAD_W +: STAT_W+ID_W+SEQ_W] = {status_in, card_id, seq};
  end

  assign in_data   = idx < IW'(DWORDS);
  assign out_data  = in_data ? data_sh[DATA_W-1 -: WORD_W] : ~crc[CRC_W-1 -: WORD_W];
  assign out_last  = out_valid && (idx == IW'(NWORDS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_sh   <= '0;
      crc       <= '1;
      idx       <= '0;
      seq       <= '0;
      out_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (tick) begin
        if (!out_valid) begin
          data_sh   <= frame_w;
          crc       <= '1;
          idx       <= '0;
          seq       <= seq + 1'b1;
          out_valid <= 1'b1;
        end else begin
          overrun <= 1'b1;
        end
      end
      if (out_valid && out_ready) begin
        idx <= idx + 1'b1;
        if (in_data) begin
          data_sh <= data_sh << WORD_W;
          crc     <= crc_step(crc, data_sh[DATA_W-1 -: WORD_W]);
        end else begin
          crc <= crc << WORD_W;
        end
        if (idx == IW'(NWORDS-1)) out_valid <= 1'b0;
      end
    end
  end

  a_r1_tick_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !out_valid) |=> (out_valid && !out_last));

  a_r4_last_only_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r5_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> !out_valid);

  a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(tick && out_valid));

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

// File: tb/frame_crc_packer_bench.sv
module frame_crc_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [95:0] adc_in = '0;
  logic [63:0] cnt_in = '0;
  logic [9:0]  status_in = '0;
  logic [9:0]  card_id = '0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_last;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  logic [15:0] seq_q[$];
  logic        m_ovr = 1'b0;
  logic [15:0] m_seq = '0;
  logic [15:0] cap[16];
  int          cap_n = 0;

  always #5 clk = ~clk;

  frame_crc_packer u_frame_crc_packer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .adc_in(adc_in), .cnt_in(cnt_in),
    .status_in(status_in), .card_id(card_id), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .overrun(overrun));

  function automatic logic [31:0] ref_crc(input logic [223:0] d);
    logic [31:0] c;
    logic fb;
    c = '1;
    for (int i = 223; i >= 0; i--) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return ~c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: one update per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete(); seq_q.delete(); m_ovr = 1'b0; m_seq = '0;
    end else begin
      automatic bit busy = exp_q.size() != 0;
      if (busy && out_ready) void'(exp_q.pop_front());
      if (tick) begin
        if (!busy) begin
          automatic logic [255:0] f = '0;
          for (int k = 0; k < 8; k++) begin
            f[255-12*k -: 12] = adc_in[12*k +: 12];
            f[159-8*k -: 8]   = cnt_in[8*k +: 8];
          end
          f[95:86] = status_in;
          f[85:76] = card_id;
          f[75:60] = m_seq;
          f[31:0]  = ref_crc(f[255:32]);
          for (int w = 0; w < 16; w++) exp_q.push_back(f[255-16*w -: 16]);
          seq_q.push_back(m_seq);
          m_seq = m_seq + 16'd1;
        end else begin
          m_ovr = 1'b1;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit mv = exp_q.size() != 0;
      chk(out_valid == mv, "R1/R5 out_valid", {31'd0, out_valid}, {31'd0, mv});
      chk(overrun == m_ovr, "R7 overrun", {31'd0, overrun}, {31'd0, m_ovr});
      if (mv && out_valid) begin
        automatic int wi = 16 - exp_q.size();
        chk(out_data == exp_q[0], (wi < 14) ? "R2/R8 data word" : "R3 crc word",
            {16'd0, out_data}, {16'd0, exp_q[0]});
        chk(out_last == (exp_q.size() == 1), "R4 out_last",
            {31'd0, out_last}, {31'd0, exp_q.size() == 1});
        if (out_ready) begin
          cap[cap_n] = out_data;
          cap_n++;
          if (cap_n == 16) begin
            automatic logic [15:0] s = {cap[11][11:0], cap[12][15:12]};
            automatic logic [15:0] es = (seq_q.size() != 0) ? seq_q.pop_front() : 16'hxxxx;
            chk(s == es, "R6 sequence number", {16'd0, s}, {16'd0, es});
            cap_n = 0;
          end
        end
      end
    end
  end

  task automatic step(input bit t, input bit r);
    @(posedge clk); #2;
    tick = t; out_ready = r;
    adc_in = {$urandom, $urandom, $urandom};
    cnt_in = {$urandom, $urandom};
    status_in = 10'($urandom);
    card_id = 10'($urandom);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !out_last && !overrun, "R9 reset state",
        {29'd0, out_valid, out_last, overrun}, 32'd0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !overrun, "R9 after reset", {30'd0, out_valid, overrun}, 32'd0);

    // R1/R2/R3/R6: back-to-back frames with free flow; inputs churn (R8)
    for (int f = 0; f < 4; f++) begin
      step(1, 1);
      repeat (16) step(0, 1);
    end
    @(negedge clk);
    chk(!overrun, "R7 no overrun yet", {31'd0, overrun}, 32'd0);

    // R7: tick in the very cycle the final word is handed over
    step(1, 1);
    for (int n = 0; n < 40; n++) begin
      @(posedge clk); #2;
      out_ready = 1'b1;
      tick = out_valid && out_last;
      adc_in = {$urandom, $urandom, $urandom};
      if (tick) break;
    end
    step(0, 1);
    @(negedge clk);
    chk(!out_valid, "R7 collision tick dropped", {31'd0, out_valid}, 32'd0);
    chk(overrun, "R7 overrun set", {31'd0, overrun}, 32'd1);
    step(1, 1);
    repeat (17) step(0, 1);

    // R5: long stall mid-frame with ticks arriving
    step(1, 1);
    repeat (5) step(0, 1);
    repeat (30) step($urandom % 4 == 0, 0);
    repeat (20) step(0, 1);

    // mixed traffic
    for (int n = 0; n < 3000; n++) step($urandom % 12 == 0, $urandom % 3 != 0);
    repeat (40) step(0, 1);
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule